// File: doc/BRIEF.md
# Multi-Channel Acquire-and-Hold Sequencer

This block is the digital core of a many-channel sample-and-hold. It keeps a 14-bit code for each of 64 output channels and for one extra offset channel. When a channel is addressed, it looks for the code whose converted level matches a shared analog input. It does this as a successive-approximation search, one bit per clock, against a single comparator bit that reports whether the trial code is too high. The code it finds is then held with no decay until that channel is addressed again.

During a search the block drives an active-low busy flag and sets a per-channel bypass select, so that the analog side routes the live input to that channel's output. A level input can defer the search: if it is low when the address arrives, the channel stays in bypass and waits for a rising edge of that input. A calibration request makes all 64 channels acquire in one search. Codes can also be written directly, to one register or to all 64 channels, and any register can be read back.

Top module: `acq_hold_seq`

## Requirements
- R1: The block holds 65 registers of 14 bits: channels 0..63 and an offset register. A read selects the offset register when `rd_ofs`=1 and channel `rd_ch` otherwise, and shows the value on `rd_code` one clock later.
- R2: A synchronous reset clears every register, including the offset register, to zero. It also forces `busy_n`=1 and `bypass`=0.
- R3: A request accepted while `track` is high starts a search at once: `busy_n` is low in the cycle after the request.
- R4: A search keeps `busy_n` low for exactly 14 cycles. On the edge where `busy_n` returns high, the target register takes the largest code for which `cmp_high` was 0, and the target's `bypass` bits clear.
- R5: A request accepted while `track` is low does not lower `busy_n`. The target's `bypass` bits stay set, and the search starts at the first clock where `track` is high after being low on the clock before.
- R6: A request with `req_cal`=1 runs one search whose result goes into all 64 channel registers. The offset register is left unchanged.
- R7: A direct write (`wr_valid`) loads `wr_code` with no search and no change to `busy_n`. It goes to the offset register if `wr_ofs`=1, to all 64 channels if `wr_all`=1 (this takes priority over `wr_ofs`), and to channel `wr_ch` otherwise.
- R8: `busy_n` is never low for more than 14 consecutive cycles.
- R9: A request that arrives while a request is armed or a search is running is held in a one-entry pending slot, where a later request replaces an earlier one. It is launched one cycle after the current search completes.
- R10: `bypass` bit k belongs to channel k, and bit 64 belongs to the offset register.
- R11: A request targets, in priority order: all channels if `req_cal`=1; else the offset register if `req_ofs`=1, ignoring `req_ch`; else channel `req_ch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Acquisition request strobe |
| req_cal | input | 1 | Request targets all 64 channels |
| req_ofs | input | 1 | Request targets the offset register |
| req_ch | input | 6 | Channel index of the request |
| track | input | 1 | High: acquire now; low: defer until rising edge |
| cmp_high | input | 1 | Comparator: trial code is above the input level |
| wr_valid | input | 1 | Direct code write strobe |
| wr_all | input | 1 | Direct write to all 64 channels |
| wr_ofs | input | 1 | Direct write to the offset register |
| wr_ch | input | 6 | Channel index of the direct write |
| wr_code | input | 14 | Code for the direct write |
| rd_ofs | input | 1 | Read the offset register |
| rd_ch | input | 6 | Channel index to read |
| trial_code | output | 14 | Trial code presented to the converter |
| busy_n | output | 1 | Low while a search runs |
| bypass | output | 65 | Per-register live-input route select |
| rd_code | output | 14 | Registered read data |

## Verification
The in-RTL assertions check on every cycle that a low busy flag always comes with some bypass bit set. They also check that the busy flag mirrors the search engine's run state, that a busy stretch never exceeds 14 cycles, that the bypass bits clear when busy rises, and that a calibration write leaves the offset register alone. Only the bench scenarios can show the search results and the deferral until a track edge. The same holds for the pending-slot replacement, the priority of target selection, and the direct writes, which the bench compares against a behavioural model and explicit read-backs on every clock.

// File: rtl/acqh_pkg.sv
package acqh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SRCH  = 2'd2
  } acqh_state_e;
endpackage

// File: rtl/acqh_sar_core.sv
module acqh_sar_core #(
  parameter int CODE_W = 14,
  localparam int SW = $clog2(CODE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cmp_high,
  output logic [CODE_W-1:0] trial_code,
  output logic              running,
  output logic              finish,
  output logic [CODE_W-1:0] result
);
  logic [SW-1:0]     step;
  logic [CODE_W-1:0] nxt;

  // Resolve the current bit, then propose the next lower one.
  always_comb begin
    nxt = trial_code;
    if (cmp_high) nxt[step] = 1'b0;
    if (step != '0) nxt[step - 1'b1] = 1'b1;
  end

  assign finish = running && (step == '0);
  assign result = nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      running    <= 1'b0;
      trial_code <= '0;
      step       <= '0;
    end else if (start) begin
      running    <= 1'b1;
      trial_code <= {1'b1, {(CODE_W-1){1'b0}}};
      step       <= SW'(CODE_W-1);
    end else if (running) begin
      trial_code <= nxt;
      step       <= step - 1'b1;
      if (step == '0) running <= 1'b0;
    end
  end

  // R3: a new search only begins from rest
  p_start_at_rest_r3: assert property (@(posedge clk) disable iff (rst)
    start |-> !running);
  // R4: the final step ends the run
  p_finish_ends_r4: assert property (@(posedge clk) disable iff (rst)
    finish |=> !running);
endmodule

// File: rtl/acqh_code_bank.sv
module acqh_code_bank #(
  parameter int NCH    = 64,
  parameter int CODE_W = 14,
  localparam int CHW  = $clog2(NCH),
  localparam int NREG = NCH + 1,
  localparam int IW   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dw_en,
  input  logic              dw_all,
  input  logic              dw_ofs,
  input  logic [CHW-1:0]    dw_ch,
  input  logic [CODE_W-1:0] dw_code,
  input  logic              aw_en,
  input  logic              aw_cal,
  input  logic              aw_ofs,
  input  logic [CHW-1:0]    aw_ch,
  input  logic [CODE_W-1:0] aw_code,
  input  logic              rd_ofs,
  input  logic [CHW-1:0]    rd_ch,
  output logic [CODE_W-1:0] rd_code
);
  localparam int OFS = NCH;

  logic [NREG-1:0][CODE_W-1:0] regs;
  logic [IW-1:0]               rd_idx;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic              dir_hit;
    logic              acq_hit;
    logic [CODE_W-1:0] q;
    if (g == OFS) begin : g_ofs
      assign dir_hit = dw_en && dw_ofs && !dw_all;
      assign acq_hit = aw_en && aw_ofs && !aw_cal;
    end else begin : g_ch
      assign dir_hit = dw_en && (dw_all || (!dw_ofs && dw_ch == CHW'(g)));
      assign acq_hit = aw_en && (aw_cal || (!aw_ofs && aw_ch == CHW'(g)));
    end
    always_ff @(posedge clk) begin
      if (rst)          q <= '0;
      else if (acq_hit) q <= aw_code;
      else if (dir_hit) q <= dw_code;
    end
    assign regs[g] = q;
  end

  assign rd_idx = rd_ofs ? IW'(OFS) : IW'(rd_ch);

  always_ff @(posedge clk) begin
    if (rst)                       rd_code <= '0;
    else if (rd_idx < IW'(NREG))   rd_code <= regs[rd_idx];
    else                           rd_code <= '0;
  end

  // R6: a broadcast result never lands in the offset register
  p_cal_spares_ofs_r6: assert property (@(posedge clk) disable iff (rst)
    (aw_en && aw_cal && !(dw_en && dw_ofs && !dw_all)) |=> $stable(regs[OFS]));
endmodule

// File: rtl/acqh_ctrl.sv
module acqh_ctrl
  import acqh_pkg::*;
#(
  parameter int NCH    = 64,
  parameter int CODE_W = 14,
  localparam int CHW = $clog2(NCH),
  localparam int RW  = $clog2(CODE_W + 2)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic           req_cal,
  input  logic           req_ofs,
  input  logic [CHW-1:0] req_ch,
  input  logic           track,
  input  logic           sar_running,
  input  logic           sar_finish,
  output logic           sar_start,
  output logic           busy_n,
  output logic [NCH:0]   bypass,
  output logic           tgt_cal,
  output logic           tgt_ofs,
  output logic [CHW-1:0] tgt_ch
);
  acqh_state_e    state;
  logic           track_q;
  logic           pend_v, pend_cal, pend_ofs;
  logic [CHW-1:0] pend_ch;
  logic           launch, arm_fire;
  logic           l_cal, l_ofs;
  logic [CHW-1:0] l_ch;

  function automatic logic [NCH:0] hit_mask(input logic c, input logic o,
                                            input logic [CHW-1:0] ch);
    logic [NCH:0] m;
    m = '0;
    if (c)      m[NCH-1:0] = '1;
    else if (o) m[NCH]     = 1'b1;
    else        m[ch]      = 1'b1;
    return m;
  endfunction

  assign launch    = (state == ST_IDLE) && (pend_v || req_valid);
  assign l_cal     = pend_v ? pend_cal : req_cal;
  assign l_ofs     = pend_v ? pend_ofs : req_ofs;
  assign l_ch      = pend_v ? pend_ch  : req_ch;
  assign arm_fire  = (state == ST_ARMED) && track && !track_q;
  assign sar_start = (launch && track) || arm_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      track_q  <= 1'b0;
      pend_v   <= 1'b0;
      pend_cal <= 1'b0;
      pend_ofs <= 1'b0;
      pend_ch  <= '0;
      busy_n   <= 1'b1;
      bypass   <= '0;
      tgt_cal  <= 1'b0;
      tgt_ofs  <= 1'b0;
      tgt_ch   <= '0;
    end else begin
      track_q <= track;
      if (req_valid) begin
        pend_cal <= req_cal;
        pend_ofs <= req_ofs;
        pend_ch  <= req_ch;
      end
      unique case (state)
        ST_IDLE: begin
          if (launch) begin
            tgt_cal <= l_cal;
            tgt_ofs <= l_ofs;
            tgt_ch  <= l_ch;
            bypass  <= hit_mask(l_cal, l_ofs, l_ch);
            if (track) begin
              state  <= ST_SRCH;
              busy_n <= 1'b0;
            end else begin
              state  <= ST_ARMED;
            end
            if (pend_v) pend_v <= req_valid;
          end
        end
        ST_ARMED: begin
          if (req_valid) pend_v <= 1'b1;
          if (arm_fire) begin
            state  <= ST_SRCH;
            busy_n <= 1'b0;
          end
        end
        ST_SRCH: begin
          if (req_valid) pend_v <= 1'b1;
          if (sar_finish) begin
            state  <= ST_IDLE;
            busy_n <= 1'b1;
            bypass <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Run-length counter used only by the bound check below.
  logic [RW-1:0] low_run;
  always_ff @(posedge clk) begin
    if (rst)          low_run <= '0;
    else if (!busy_n) low_run <= low_run + 1'b1;
    else              low_run <= '0;
  end

  // R8: busy never stays low past one full search
  p_busy_bound_r8: assert property (@(posedge clk) disable iff (rst)
    low_run <= RW'(CODE_W));
  // R4: busy tracks the search engine
  p_busy_is_search_r4: assert property (@(posedge clk) disable iff (rst)
    busy_n != sar_running);
  // R10: while searching some channel is routed to the live input
  p_busy_has_bypass_r10: assert property (@(posedge clk) disable iff (rst)
    !busy_n |-> (bypass != '0));
  // R4: bypass is released together with busy
  p_release_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_n) |-> (bypass == '0));
  // R5: an armed request shows bypass but not busy
  p_armed_idle_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED) |-> (busy_n && bypass != '0));
  // R9: a held request launches right after completion
  p_pend_launch_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SRCH && sar_finish && req_valid) |=> ##1 (state != ST_IDLE));
endmodule

// File: rtl/acq_hold_seq.sv
module acq_hold_seq #(
  parameter int NCH    = 64,
  parameter int CODE_W = 14,
  localparam int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_cal,
  input  logic              req_ofs,
  input  logic [CHW-1:0]    req_ch,
  input  logic              track,
  input  logic              cmp_high,
  input  logic              wr_valid,
  input  logic              wr_all,
  input  logic              wr_ofs,
  input  logic [CHW-1:0]    wr_ch,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              rd_ofs,
  input  logic [CHW-1:0]    rd_ch,
  output logic [CODE_W-1:0] trial_code,
  output logic              busy_n,
  output logic [NCH:0]      bypass,
  output logic [CODE_W-1:0] rd_code
);
  logic              sar_start, sar_running, sar_finish;
  logic [CODE_W-1:0] sar_result;
  logic              tgt_cal, tgt_ofs;
  logic [CHW-1:0]    tgt_ch;

  acqh_ctrl #(.NCH(NCH), .CODE_W(CODE_W)) ctrl_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_cal(req_cal), .req_ofs(req_ofs), .req_ch(req_ch),
    .track(track), .sar_running(sar_running), .sar_finish(sar_finish),
    .sar_start(sar_start), .busy_n(busy_n), .bypass(bypass),
    .tgt_cal(tgt_cal), .tgt_ofs(tgt_ofs), .tgt_ch(tgt_ch)
  );

  acqh_sar_core #(.CODE_W(CODE_W)) sar_i (
    .clk(clk), .rst(rst), .start(sar_start), .cmp_high(cmp_high),
    .trial_code(trial_code), .running(sar_running), .finish(sar_finish),
    .result(sar_result)
  );

  acqh_code_bank #(.NCH(NCH), .CODE_W(CODE_W)) bank_i (
    .clk(clk), .rst(rst),
    .dw_en(wr_valid), .dw_all(wr_all), .dw_ofs(wr_ofs), .dw_ch(wr_ch), .dw_code(wr_code),
    .aw_en(sar_finish), .aw_cal(tgt_cal), .aw_ofs(tgt_ofs), .aw_ch(tgt_ch),
    .aw_code(sar_result),
    .rd_ofs(rd_ofs), .rd_ch(rd_ch), .rd_code(rd_code)
  );
endmodule

// File: tb/acq_hold_seq_tb_top.sv
`timescale 1ns/1ps
module acq_hold_seq_tb_top;
  localparam int NCH = 64;
  localparam int W   = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_cal = 0, req_ofs = 0;
  logic [5:0] req_ch = '0;
  logic track = 1'b1;
  logic cmp_high;
  logic wr_valid = 0, wr_all = 0, wr_ofs = 0;
  logic [5:0] wr_ch = '0;
  logic [W-1:0] wr_code = '0;
  logic rd_ofs = 0;
  logic [5:0] rd_ch = '0;
  logic [W-1:0] trial_code, rd_code;
  logic busy_n;
  logic [NCH:0] bypass;
  logic [W-1:0] level = '0;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign cmp_high = (trial_code > level);

  acq_hold_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cal(req_cal), .req_ofs(req_ofs),
    .req_ch(req_ch), .track(track), .cmp_high(cmp_high), .wr_valid(wr_valid),
    .wr_all(wr_all), .wr_ofs(wr_ofs), .wr_ch(wr_ch), .wr_code(wr_code),
    .rd_ofs(rd_ofs), .rd_ch(rd_ch), .trial_code(trial_code), .busy_n(busy_n),
    .bypass(bypass), .rd_code(rd_code)
  );

  // ---------------- behavioural reference model ----------------
  int m_mem[NCH+1];
  int m_state;              // 0 idle, 1 waiting for track edge, 2 acquiring
  int m_left;               // cycles of acquisition remaining
  bit m_busy_n;
  bit [NCH:0] m_byp;
  int m_rd;
  bit m_trk_prev;
  bit m_pv; bit m_pc, m_po; int m_pch;
  bit m_tc, m_to; int m_tch;

  function automatic bit [NCH:0] targets(bit c, bit o, int ch);
    bit [NCH:0] t = '0;
    if (c) for (int i = 0; i < NCH; i++) t[i] = 1'b1;
    else if (o) t[NCH] = 1'b1;
    else t[ch] = 1'b1;
    return t;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      m_state = 0; m_left = 0; m_busy_n = 1; m_byp = '0; m_rd = 0;
      m_trk_prev = 0; m_pv = 0;
    end else begin
      bit [NCH:0] hit;
      bit go_c, go_o; int go_ch;
      m_rd = m_mem[rd_ofs ? NCH : rd_ch];
      if (wr_valid) begin
        if (wr_all) for (int i = 0; i < NCH; i++) m_mem[i] = wr_code;
        else if (wr_ofs) m_mem[NCH] = wr_code;
        else m_mem[wr_ch] = wr_code;
      end
      if (m_state == 0) begin
        if (m_pv || req_valid) begin
          if (m_pv) begin go_c = m_pc; go_o = m_po; go_ch = m_pch; end
          else begin go_c = req_cal; go_o = req_ofs; go_ch = req_ch; end
          if (m_pv) begin
            m_pv = req_valid;
            m_pc = req_cal; m_po = req_ofs; m_pch = req_ch;
          end
          m_tc = go_c; m_to = go_o; m_tch = go_ch;
          m_byp = targets(go_c, go_o, go_ch);
          if (track) begin m_state = 2; m_left = W; m_busy_n = 0; end
          else m_state = 1;
        end
      end else begin
        if (req_valid) begin
          m_pv = 1; m_pc = req_cal; m_po = req_ofs; m_pch = req_ch;
        end
        if (m_state == 1) begin
          if (track && !m_trk_prev) begin m_state = 2; m_left = W; m_busy_n = 0; end
        end else begin
          m_left--;
          if (m_left == 0) begin
            hit = targets(m_tc, m_to, m_tch);
            for (int i = 0; i <= NCH; i++) if (hit[i]) m_mem[i] = level;
            m_state = 0; m_busy_n = 1; m_byp = '0;
          end
        end
      end
      m_trk_prev = track;
    end
  end

  // every-clock comparison
  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (busy_n !== m_busy_n) begin
        errors++; $display("FAIL R4 busy_n act=%0b exp=%0b t=%0t", busy_n, m_busy_n, $time);
      end
      checks++;
      if (bypass !== m_byp) begin
        errors++; $display("FAIL R10 bypass act=%h exp=%h t=%0t", bypass, m_byp, $time);
      end
      checks++;
      if (rd_code !== W'(m_rd)) begin
        errors++; $display("FAIL R1 rd_code act=%h exp=%h t=%0t", rd_code, m_rd, $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++; $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic request(input bit c, input bit o, input int ch);
    req_cal = c; req_ofs = o; req_ch = 6'(ch); req_valid = 1;
    @(negedge clk);
    req_valid = 0; req_cal = 0; req_ofs = 0;
  endtask

  task automatic dwrite(input bit all, input bit o, input int ch, input int code);
    wr_all = all; wr_ofs = o; wr_ch = 6'(ch); wr_code = W'(code); wr_valid = 1;
    @(negedge clk);
    wr_valid = 0; wr_all = 0; wr_ofs = 0;
  endtask

  task automatic rd_chk(input string req, input bit o, input int ch, input int exp);
    rd_ofs = o; rd_ch = 6'(ch);
    @(negedge clk);
    chk(req, rd_code, exp);
  endtask

  task automatic wait_quiet();
    while (!(m_state == 0 && !m_pv && busy_n)) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  // ---------------- scenarios ----------------
  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R2: reset state
    chk("R2 busy_n", busy_n, 1);
    chk("R2 bypass", int'(bypass != '0), 0);
    rd_chk("R2 ch0", 0, 0, 0);
    rd_chk("R2 ch63", 0, 63, 0);
    rd_chk("R2 ofs", 1, 0, 0);

    // R3/R4: immediate acquisition with track high
    level = 14'h1ABC; track = 1;
    request(0, 0, 5);
    chk("R3 busy low next cycle", busy_n, 0);
    n = 0;
    while (busy_n == 0) begin n++; @(negedge clk); end
    chk("R4 busy length", n, 14);
    rd_chk("R4 ch5 result", 0, 5, 14'h1ABC);

    // R11: offset flag overrides channel index
    level = 14'h0FFF;
    request(0, 1, 7);
    wait_quiet();
    rd_chk("R11 ofs result", 1, 0, 14'h0FFF);
    rd_chk("R11 ch7 untouched", 0, 7, 0);

    // R5/R10: deferred by track low, then started by rising edge
    level = 14'h3FFF; track = 0;
    request(0, 0, 9);
    repeat (5) @(negedge clk);
    chk("R5 not busy while armed", busy_n, 1);
    chk("R10 bypass bit 9", bypass[9], 1);
    track = 1;
    @(negedge clk);
    chk("R5 busy after track rise", busy_n, 0);
    wait_quiet();
    rd_chk("R5 ch9 full scale", 0, 9, 14'h3FFF);

    // R10: offset bypass is bit 64
    track = 0; level = 14'h0000;
    request(0, 1, 0);
    @(negedge clk);
    chk("R10 bypass bit 64", bypass[NCH], 1);
    track = 1;
    wait_quiet();
    rd_chk("R4 ofs zero level", 1, 0, 0);

    // R6: calibration fills all channels, spares offset
    level = 14'h0123;
    dwrite(0, 1, 0, 14'h0FFF);
    request(1, 1, 3);
    @(negedge clk);
    chk("R6 bypass all channels", int'(bypass[NCH-1:0] == '1), 1);
    wait_quiet();
    rd_chk("R6 ch0", 0, 0, 14'h0123);
    rd_chk("R6 ch63", 0, 63, 14'h0123);
    rd_chk("R6 ofs spared", 1, 0, 14'h0FFF);

    // R7: direct writes, one during a search
    level = 14'h2000;
    request(0, 0, 20);
    dwrite(0, 0, 3, 14'h2222);
    chk("R7 busy unchanged by write", busy_n, 0);
    wait_quiet();
    rd_chk("R7 ch3 direct", 0, 3, 14'h2222);
    dwrite(1, 1, 0, 14'h0555);
    rd_chk("R7 all ch40", 0, 40, 14'h0555);
    rd_chk("R7 all spares ofs", 1, 0, 14'h0FFF);
    dwrite(0, 1, 0, 14'h3000);
    rd_chk("R7 ofs direct", 1, 0, 14'h3000);

    // R9: pending request, latest wins, 1-cycle gap
    level = 14'h1111;
    request(0, 0, 10);
    request(0, 0, 12);
    request(0, 0, 13);
    while (busy_n == 0) @(negedge clk);
    n = 0;
    while (busy_n == 1) begin n++; @(negedge clk); end
    chk("R9 gap before pending launch", n, 1);
    wait_quiet();
    rd_chk("R9 ch10", 0, 10, 14'h1111);
    rd_chk("R9 ch13 latest", 0, 13, 14'h1111);
    rd_chk("R9 ch12 replaced", 0, 12, 14'h0555);

    // R8/R1: odd level on last channel
    level = 14'h2AAA;
    request(0, 0, 63);
    n = 0;
    while (busy_n == 0) begin n++; @(negedge clk); end
    chk("R8 busy bound", int'(n <= 14), 1);
    rd_chk("R1 ch63 readback", 0, 63, 14'h2AAA);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule